// File: doc/BRIEF.md
# Virtual-8086 Mode Controller and Rule Checker

This block keeps the live virtual-8086 (VM) state of an x86-style core and applies the rules that depend on it. It watches three kinds of input. The first is the retiring instruction's class. The second is a strobe that carries the VM bit of any EFLAGS image being loaded, together with where that image came from (POPF, IRET or a task switch). The third is an interrupt or exception event strobe, which arrives with the attributes of the gate it targets.

From these inputs the block produces three results. It returns a registered VM flag. It returns a registered one-cycle general-protection fault strobe. It also computes the real-mode-style linear address (segment times 16 plus offset) that V86 code uses.

A two-state machine holds the mode, with the states `ST_NATIVE` and `ST_V86`. Three transitions move it. `ENTER_IRET` goes from native to V86 on an IRET load at privilege 0 whose image has VM set. `ENTER_TASKSW` goes from native to V86 on a task-switch load whose image has VM set. `EXIT_GATE` goes from V86 to native on an event whose target is a legal exit. Any other event in V86 keeps the state and raises a fault.

Paging, descriptor fetches, decoding and stack traffic are handled elsewhere. Their results reach this block as plain inputs.

Top module: `v86_mode_ctl`

## Requirements
- R1: After reset `vm_flag` is 0 and `gp_fault` is 0.
- R2: While `vm_flag` is 1, `lin_addr` equals `seg_val`*16 + `seg_off`, including the carry into the top bit. While `vm_flag` is 0, `lin_addr` is 0.
- R3: `eff_cpl` is 3 while `vm_flag` is 1 and equals `cpl` otherwise.
- R4: In V86, a retiring instruction of class CLI=1, STI=2, PUSHF=3, POPF=4, INTn=5 or IRET=6 with `iopl` below 3 sets `gp_fault` for exactly the one cycle after the edge that samples it. With `iopl`=3 it raises no fault.
- R5: In V86, the classes INT3=7, INTO=8 and BOUND=9 never raise a fault, whatever `iopl` is.
- R6: In V86, class PRIV=10 always raises `gp_fault` on the next cycle. Outside V86, no instruction class raises a fault.
- R7: From native, `flag_load` with `flag_src`=1 (IRET), `cpl`=0 and `flag_img_vm`=1 sets `vm_flag` on the next edge. With `cpl` other than 0, the same load leaves `vm_flag` at 0.
- R8: From native, `flag_load` with `flag_src`=2 (task switch) and `flag_img_vm`=1 sets `vm_flag` at any `cpl`.
- R9: A load with `flag_src`=0 (POPF) never changes `vm_flag`. While in V86, no flag load of any source changes `vm_flag`.
- R10: In V86, an event whose `gate_kind` is 0 (32-bit trap) or 1 (32-bit interrupt) with `tgt_conforming`=0 and `tgt_dpl`=0, or whose `gate_kind` is 2 (32-bit TSS), clears `vm_flag` on the next edge without a fault.
- R11: In V86, an event of any other form sets `gp_fault` on the next cycle and leaves `vm_flag` at 1. The illegal forms are `gate_kind`=3, a conforming target, or a nonzero target DPL on a trap or interrupt gate.
- R12: In native mode, events have no effect on `vm_flag` or `gp_fault`.
- R13: When a faulting instruction and a legal exit event are sampled together in V86, `gp_fault` is raised and `vm_flag` clears on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_class | input | 4 | Class code of the retiring instruction |
| cpl | input | 2 | Current privilege level from the core |
| iopl | input | 2 | I/O privilege level field |
| flag_load | input | 1 | An EFLAGS image is being loaded |
| flag_src | input | 2 | Origin of the load: 0 POPF, 1 IRET, 2 task switch |
| flag_img_vm | input | 1 | VM bit (bit 17) of the loaded image |
| evt_valid | input | 1 | Interrupt or exception being delivered |
| gate_kind | input | 2 | Target kind: 0 trap32, 1 int32, 2 TSS32, 3 other |
| tgt_conforming | input | 1 | Gate target segment is conforming |
| tgt_dpl | input | 2 | DPL of the gate target segment |
| seg_val | input | SEG_W | Segment register value |
| seg_off | input | OFF_W | Offset within segment |
| vm_flag | output | 1 | Live VM flag |
| gp_fault | output | 1 | General-protection fault strobe |
| eff_cpl | output | 2 | Effective privilege level |
| lin_addr | output | LIN_W | V86 linear address |

## Verification
The clash that matters is an instruction fault and a mode exit landing in the same cycle. One path produces the fault strobe and the other moves the state register. The scenario puts the block in V86 with IOPL 0. It then retires a sensitive instruction in the same cycle that a legal 32-bit interrupt gate event arrives. The bench expects both the fault strobe and the cleared VM flag after that single edge, and then expects the strobe to drop a cycle later. A second pairing drives an illegal gate together with a privileged instruction. There the fault must show once while VM stays set.

// File: rtl/v86_pkg.sv
package v86_pkg;

    typedef enum logic [3:0] {
        IC_OTHER = 4'd0,
        IC_CLI   = 4'd1,
        IC_STI   = 4'd2,
        IC_PUSHF = 4'd3,
        IC_POPF  = 4'd4,
        IC_INTN  = 4'd5,
        IC_IRET  = 4'd6,
        IC_INT3  = 4'd7,
        IC_INTO  = 4'd8,
        IC_BOUND = 4'd9,
        IC_PRIV  = 4'd10
    } insn_class_e;

    typedef enum logic [1:0] {
        FS_POPF   = 2'd0,
        FS_IRET   = 2'd1,
        FS_TASKSW = 2'd2,
        FS_NONE   = 2'd3
    } flag_src_e;

    typedef enum logic [1:0] {
        GK_TRAP32 = 2'd0,
        GK_INT32  = 2'd1,
        GK_TSS32  = 2'd2,
        GK_OTHER  = 2'd3
    } gate_kind_e;

    typedef enum logic {
        ST_NATIVE = 1'b0,
        ST_V86    = 1'b1
    } vm_state_e;

    localparam logic [1:0] RING0 = 2'd0;
    localparam logic [1:0] RING3 = 2'd3;

endpackage

// File: rtl/v86_insn_check.sv
module v86_insn_check
    import v86_pkg::*;
(
    input  logic        in_v86,
    input  logic        retire_valid,
    input  insn_class_e cls,
    input  logic [1:0]  iopl,
    output logic        fault
);
    logic sensitive;
    logic privileged;

    // Sensitive set differs from protected mode; INT3/INTO/BOUND excluded.
    always_comb begin
        sensitive  = 1'b0;
        privileged = 1'b0;
        case (cls)
            IC_CLI, IC_STI, IC_PUSHF, IC_POPF, IC_INTN, IC_IRET: sensitive = 1'b1;
            IC_PRIV:                                             privileged = 1'b1;
            default:                                             ;
        endcase
        fault = in_v86 && retire_valid &&
                (privileged || (sensitive && (iopl != RING3)));
    end

endmodule

// File: rtl/v86_gate_check.sv
module v86_gate_check
    import v86_pkg::*;
(
    input  gate_kind_e kind,
    input  logic       conforming,
    input  logic [1:0] dpl,
    output logic       legal
);
    logic via_gate;

    always_comb begin
        via_gate = (kind == GK_TRAP32) || (kind == GK_INT32);
        legal    = (kind == GK_TSS32) ||
                   (via_gate && !conforming && (dpl == RING0));
    end

endmodule

// File: rtl/v86_addr_gen.sv
module v86_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int LIN_W = 21
) (
    input  logic             en,
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [LIN_W-1:0] lin
);
    localparam int SHIFT = 4;

    logic [LIN_W-1:0] seg_x;
    logic [LIN_W-1:0] off_x;

    always_comb begin
        seg_x = LIN_W'({seg, {SHIFT{1'b0}}});
        off_x = LIN_W'(off);
        lin   = en ? (seg_x + off_x) : '0;
    end

endmodule

// File: rtl/v86_mode_ctl.sv
module v86_mode_ctl
    import v86_pkg::*;
#(
    parameter  int SEG_W = 16,
    parameter  int OFF_W = 16,
    localparam int LIN_W = (((SEG_W + 4) > OFF_W) ? (SEG_W + 4) : OFF_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_valid,
    input  logic [3:0]       retire_class,
    input  logic [1:0]       cpl,
    input  logic [1:0]       iopl,
    input  logic             flag_load,
    input  logic [1:0]       flag_src,
    input  logic             flag_img_vm,
    input  logic             evt_valid,
    input  logic [1:0]       gate_kind,
    input  logic             tgt_conforming,
    input  logic [1:0]       tgt_dpl,
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFF_W-1:0] seg_off,
    output logic             vm_flag,
    output logic             gp_fault,
    output logic [1:0]       eff_cpl,
    output logic [LIN_W-1:0] lin_addr
);
    vm_state_e state_q;
    vm_state_e state_d;
    logic      in_v86;
    logic      insn_fault;
    logic      gate_ok;
    logic      gate_fault;
    logic      enter_iret;
    logic      enter_tasksw;
    logic      gp_q;

    assign in_v86 = (state_q == ST_V86);

    v86_insn_check u_insn (
        .in_v86       (in_v86),
        .retire_valid (retire_valid),
        .cls          (insn_class_e'(retire_class)),
        .iopl         (iopl),
        .fault        (insn_fault)
    );

    v86_gate_check u_gate (
        .kind       (gate_kind_e'(gate_kind)),
        .conforming (tgt_conforming),
        .dpl        (tgt_dpl),
        .legal      (gate_ok)
    );

    v86_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .LIN_W (LIN_W)
    ) u_addr (
        .en  (in_v86),
        .seg (seg_val),
        .off (seg_off),
        .lin (lin_addr)
    );

    // Transition conditions
    always_comb begin
        enter_iret   = flag_load && (flag_src_e'(flag_src) == FS_IRET) &&
                       (cpl == RING0) && flag_img_vm;
        enter_tasksw = flag_load && (flag_src_e'(flag_src) == FS_TASKSW) &&
                       flag_img_vm;
    end

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        gate_fault = 1'b0;
        unique case (state_q)
            ST_NATIVE: begin
                if (enter_iret || enter_tasksw) begin
                    state_d = ST_V86;
                end
            end
            ST_V86: begin
                if (evt_valid) begin
                    if (gate_ok) begin
                        state_d = ST_NATIVE;   // EXIT_GATE
                    end else begin
                        gate_fault = 1'b1;
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NATIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gp_q <= 1'b0;
        end else begin
            gp_q <= insn_fault || gate_fault;
        end
    end

    assign vm_flag  = in_v86;
    assign gp_fault = gp_q;
    assign eff_cpl  = in_v86 ? RING3 : cpl;

endmodule

// File: rtl/v86_mode_chk.sv
module v86_mode_chk #(
    parameter int LIN_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire_valid,
    input logic [3:0]       retire_class,
    input logic             flag_load,
    input logic [1:0]       flag_src,
    input logic             evt_valid,
    input logic [1:0]       gate_kind,
    input logic             vm_flag,
    input logic             gp_fault,
    input logic [1:0]       eff_cpl,
    input logic [LIN_W-1:0] lin_addr
);

    assert_v86_ring3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vm_flag |-> (eff_cpl == 2'd3));

    assert_native_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vm_flag |-> (lin_addr == '0));

    assert_priv_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_flag && retire_valid && retire_class == 4'd10) |=> gp_fault);

    assert_popf_no_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!vm_flag && !(flag_load && flag_src != 2'd0)) |=> !vm_flag);

    assert_exit_by_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vm_flag) |-> $past(evt_valid));

    assert_bad_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_flag && evt_valid && gate_kind == 2'd3) |=> (gp_fault && vm_flag));

    assert_native_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !vm_flag |=> !gp_fault);

endmodule

bind v86_mode_ctl v86_mode_chk #(.LIN_W(LIN_W)) i_v86_mode_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire_valid (retire_valid),
    .retire_class (retire_class),
    .flag_load    (flag_load),
    .flag_src     (flag_src),
    .evt_valid    (evt_valid),
    .gate_kind    (gate_kind),
    .vm_flag      (vm_flag),
    .gp_fault     (gp_fault),
    .eff_cpl      (eff_cpl),
    .lin_addr     (lin_addr)
);

// File: tb/test_v86_mode_ctl.sv
module test_v86_mode_ctl;

    localparam int SEG_W = 16;
    localparam int OFF_W = 16;
    localparam int LIN_W = 21;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             retire_valid;
    logic [3:0]       retire_class;
    logic [1:0]       cpl;
    logic [1:0]       iopl;
    logic             flag_load;
    logic [1:0]       flag_src;
    logic             flag_img_vm;
    logic             evt_valid;
    logic [1:0]       gate_kind;
    logic             tgt_conforming;
    logic [1:0]       tgt_dpl;
    logic [SEG_W-1:0] seg_val;
    logic [OFF_W-1:0] seg_off;
    logic             vm_flag;
    logic             gp_fault;
    logic [1:0]       eff_cpl;
    logic [LIN_W-1:0] lin_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    v86_mode_ctl #(.SEG_W(SEG_W), .OFF_W(OFF_W)) i_v86_mode_ctl (
        .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid),
        .retire_class(retire_class), .cpl(cpl), .iopl(iopl),
        .flag_load(flag_load), .flag_src(flag_src), .flag_img_vm(flag_img_vm),
        .evt_valid(evt_valid), .gate_kind(gate_kind),
        .tgt_conforming(tgt_conforming), .tgt_dpl(tgt_dpl),
        .seg_val(seg_val), .seg_off(seg_off), .vm_flag(vm_flag),
        .gp_fault(gp_fault), .eff_cpl(eff_cpl), .lin_addr(lin_addr)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        retire_valid = 0; retire_class = 0; flag_load = 0; flag_src = 2'd3;
        flag_img_vm = 0; evt_valid = 0; gate_kind = 0; tgt_conforming = 0;
        tgt_dpl = 0;
    endtask

    task automatic do_reset();
        idle();
        cpl = 0; iopl = 0; seg_val = 0; seg_off = 0;
        rst_n = 0;
        cyc(); cyc();
        rst_n = 1;
        cyc();
    endtask

    task automatic load(logic [1:0] src, logic vm, logic [1:0] pl);
        flag_load = 1; flag_src = src; flag_img_vm = vm; cpl = pl;
        cyc();
        idle(); cpl = 0;
    endtask

    task automatic enter_v86();
        load(2'd1, 1'b1, 2'd0);
    endtask

    task automatic event_in(logic [1:0] kind, logic conf, logic [1:0] dpl);
        evt_valid = 1; gate_kind = kind; tgt_conforming = conf; tgt_dpl = dpl;
        cyc();
        idle();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 vm after reset", vm_flag, 0);
        chk("R1 gp after reset", gp_fault, 0);
    endtask

    task automatic t_iret_entry();
        do_reset();
        load(2'd1, 1'b1, 2'd3);
        chk("R7 IRET at cpl3 no entry", vm_flag, 0);
        load(2'd1, 1'b0, 2'd0);
        chk("R7 IRET image VM=0 no entry", vm_flag, 0);
        load(2'd1, 1'b1, 2'd0);
        chk("R7 IRET at cpl0 enters", vm_flag, 1);
    endtask

    task automatic t_tasksw_entry();
        do_reset();
        load(2'd2, 1'b1, 2'd3);
        chk("R8 task switch enters at cpl3", vm_flag, 1);
    endtask

    task automatic t_popf();
        do_reset();
        load(2'd0, 1'b1, 2'd0);
        chk("R9 POPF cannot enter", vm_flag, 0);
        enter_v86();
        load(2'd0, 1'b0, 2'd0);
        chk("R9 POPF cannot leave", vm_flag, 1);
        load(2'd2, 1'b0, 2'd0);
        chk("R9 task load in V86 ignored", vm_flag, 1);
    endtask

    task automatic t_addr_cpl();
        do_reset();
        seg_val = 16'h1234; seg_off = 16'h5678; cpl = 2'd1;
        #1;
        chk("R2 native addr zero", lin_addr, 0);
        chk("R3 native eff_cpl", eff_cpl, 1);
        enter_v86();
        seg_val = 16'h1234; seg_off = 16'h5678; cpl = 2'd0;
        #1;
        chk("R2 V86 addr", lin_addr, 32'h179B8);
        chk("R3 V86 eff_cpl", eff_cpl, 3);
        seg_val = 16'hFFFF; seg_off = 16'hFFFF;
        #1;
        chk("R2 V86 addr carry", lin_addr, 32'h10FFEF);
    endtask

    task automatic t_sensitive();
        do_reset();
        enter_v86();
        for (int c = 1; c <= 6; c++) begin
            for (int p = 0; p < 4; p++) begin
                iopl = p[1:0]; retire_valid = 1; retire_class = c[3:0];
                cyc();
                idle();
                chk($sformatf("R4 class %0d iopl %0d", c, p), gp_fault, (p != 3) ? 1 : 0);
                cyc();
                chk("R4 pulse one cycle", gp_fault, 0);
            end
        end
        iopl = 0;
    endtask

    task automatic t_int_variants();
        do_reset();
        enter_v86();
        for (int c = 7; c <= 9; c++) begin
            iopl = 0; retire_valid = 1; retire_class = c[3:0];
            cyc();
            idle();
            chk($sformatf("R5 class %0d no fault", c), gp_fault, 0);
        end
    endtask

    task automatic t_priv();
        do_reset();
        iopl = 0; retire_valid = 1; retire_class = 4'd10;
        cyc();
        retire_class = 4'd1;
        cyc();
        idle();
        chk("R6 native no fault", gp_fault, 0);
        enter_v86();
        iopl = 3; retire_valid = 1; retire_class = 4'd10;
        cyc();
        idle();
        chk("R6 V86 priv faults at iopl3", gp_fault, 1);
        iopl = 0;
    endtask

    task automatic t_exit_legal();
        for (int k = 0; k < 3; k++) begin
            do_reset();
            enter_v86();
            event_in(k[1:0], 1'b0, 2'd0);
            chk($sformatf("R10 kind %0d exits", k), vm_flag, 0);
            chk("R10 no fault", gp_fault, 0);
        end
        do_reset();
        enter_v86();
        event_in(2'd2, 1'b1, 2'd3);
        chk("R10 TSS ignores target attrs", vm_flag, 0);
    endtask

    task automatic t_exit_illegal();
        do_reset();
        enter_v86();
        event_in(2'd3, 1'b0, 2'd0);
        chk("R11 other kind faults", gp_fault, 1);
        chk("R11 other kind stays", vm_flag, 1);
        event_in(2'd1, 1'b1, 2'd0);
        chk("R11 conforming faults", gp_fault, 1);
        chk("R11 conforming stays", vm_flag, 1);
        event_in(2'd0, 1'b0, 2'd3);
        chk("R11 dpl3 faults", gp_fault, 1);
        chk("R11 dpl3 stays", vm_flag, 1);
    endtask

    task automatic t_native_evt();
        do_reset();
        event_in(2'd3, 1'b1, 2'd2);
        chk("R12 native event no fault", gp_fault, 0);
        chk("R12 native event vm", vm_flag, 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        enter_v86();
        iopl = 0; retire_valid = 1; retire_class = 4'd2;
        evt_valid = 1; gate_kind = 2'd1; tgt_conforming = 0; tgt_dpl = 0;
        cyc();
        idle();
        chk("R13 fault with exit", gp_fault, 1);
        chk("R13 vm cleared with fault", vm_flag, 0);
        cyc();
        chk("R13 fault drops", gp_fault, 0);
        enter_v86();
        retire_valid = 1; retire_class = 4'd10; evt_valid = 1; gate_kind = 2'd3;
        cyc();
        idle();
        chk("R13 priv plus bad gate faults", gp_fault, 1);
        chk("R13 priv plus bad gate stays", vm_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle();
        cpl = 0; iopl = 0; seg_val = 0; seg_off = 0;
        @(negedge clk);
        t_reset();
        t_iret_entry();
        t_tasksw_entry();
        t_popf();
        t_addr_cpl();
        t_sensitive();
        t_int_variants();
        t_priv();
        t_exit_legal();
        t_exit_illegal();
        t_native_evt();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule